// File: doc/BRIEF.md
# Fractional Fixed-Point Multiply-Accumulate Unit

This block is a one-stage multiply-accumulate datapath for signed fractional operands whose radix point sits directly after the sign bit, so every operand lies in [-1, +1). On each clock edge it forms the product of its two operands and may add that product to a guard-extended accumulator, subtract it, load it in place of the old contents, or leave the accumulator alone. Because one operation finishes per edge, a filter tap can be issued on every cycle with no stall.

The product is the double-width fractional result, moved left one place so that the duplicate sign bit is gone. The accumulator adds guard bits above the product's sign, so a long run of taps does not wrap. A separate readout strobe turns the accumulator into a narrow output word. It applies the selected rounding mode (truncate, round half up, or round half to even) and then clamps to the output range, registers the word, and raises a sticky flag whenever a clamp happened.

Top module: `fmac_core`

## Requirements
- R1: After reset the accumulator holds zero, `result` is zero and `sat_flag` is low.
- R2: The product of operands a and b (Q1.(W-1) each) equals 2*a*b as a Q1.(2W-1) value. The one case a = b = -1 gives the largest positive product 2^(2W-1)-1.
- R3: The `op` code selects the accumulator update at the clock edge: 0 keeps it, 1 adds the product, 2 subtracts the product, 3 loads the product and discards the old contents. Accumulator arithmetic wraps modulo 2^(2W+G).
- R4: A high `clr` sets the accumulator to zero and `sat_flag` low at the edge, whatever `op` is.
- R5: A new operation is accepted on every edge. Back-to-back operations each see the accumulator left by the one before.
- R6: Readout keeps the accumulator bits from position W upward, so the output is a Q1.(W-1) word. With `rnd_mode` 0 the dropped W bits are discarded (round toward minus infinity).
- R7: With `rnd_mode` 1, one is added to the kept part when the dropped bits are at least one half (top dropped bit set).
- R8: With `rnd_mode` 2, one is added when the dropped bits exceed one half. At exactly one half, one is added only if the kept LSB is 1, so the kept LSB ends up 0.
- R9: Rounding comes before saturation. A rounded value above 2^(W-1)-1 stores 2^(W-1)-1, and one below -2^(W-1) stores -2^(W-1).
- R10: `sat_flag` goes high at an edge where a readout clamps, and stays high until `clr` or reset. `clr` wins over a clamp in the same cycle.
- R11: When `rd_en` is high, `result` takes the rounded, saturated value of the accumulator as it was before that edge. When `rd_en` is low, `result` is unchanged.
- R12: `rnd_mode` 3 behaves the same as truncation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| clr | input | 1 | Zero the accumulator and the sticky flag |
| op | input | 2 | Accumulator update: 0 keep, 1 add, 2 subtract, 3 load |
| opnd_a | input | OP_W | Signed fractional operand a |
| opnd_b | input | OP_W | Signed fractional operand b |
| rnd_mode | input | 2 | Readout rounding: 0 truncate, 1 half up, 2 half to even, 3 truncate |
| rd_en | input | 1 | Capture the rounded, saturated accumulator into `result` |
| result | output | OUT_W | Registered narrow signed result |
| sat_flag | output | 1 | Sticky flag: a readout clamped since the last clear |

## Verification
The bench builds exact one-half, just-above-half and just-below-half accumulator fractions for both signs. A design that added the rounding bit unconditionally, or ignored the kept LSB at the tie, would return odd or biased words. It feeds -1 times -1, which a plain shifter would wrap to -1. It also loads the largest accumulator value under half-up rounding, which catches saturation applied before rounding, since that would return an overflowed negative word. Long positive and negative accumulations check the clamp direction and the flag: a flag that dropped on the next clean read, or a `clr` that lost to `op`, would show up at the ports.

// File: rtl/fmac_pkg.sv
`timescale 1ns/1ps
package fmac_pkg;
    typedef enum logic [1:0] {
        OP_KEEP = 2'd0,
        OP_ADD  = 2'd1,
        OP_SUB  = 2'd2,
        OP_LOAD = 2'd3
    } mac_op_e;

    typedef enum logic [1:0] {
        RND_TRUNC  = 2'd0,
        RND_HALFUP = 2'd1,
        RND_EVEN   = 2'd2,
        RND_TRUNC3 = 2'd3
    } rnd_mode_e;
endpackage

// File: rtl/fmac_mult.sv
`timescale 1ns/1ps
module fmac_mult #(
    parameter int OP_W = 16
) (
    input  logic signed [OP_W-1:0]   a,
    input  logic signed [OP_W-1:0]   b,
    output logic signed [2*OP_W-1:0] prod
);
    localparam int PW = 2 * OP_W;
    localparam logic signed [OP_W-1:0] OP_MIN = {1'b1, {(OP_W-1){1'b0}}};
    localparam logic signed [PW-1:0]   P_MAX  = {1'b0, {(PW-1){1'b1}}};

    logic signed [PW-1:0] raw;
    logic                 both_min;

    always_comb begin
        raw      = a * b;
        both_min = (a == OP_MIN) && (b == OP_MIN);
        prod     = both_min ? P_MAX : (raw <<< 1);
    end

    // R2: a product of two nonzero operands carries the xor of their signs
    always_comb begin
        if (a != '0 && b != '0 && !both_min) begin
            p_sign_r2: assert (prod[PW-1] == (a[OP_W-1] ^ b[OP_W-1]));
        end
    end
endmodule

// File: rtl/fmac_rndsat.sv
`timescale 1ns/1ps
module fmac_rndsat
    import fmac_pkg::*;
#(
    parameter int OP_W  = 16,
    parameter int ACC_W = 40,
    parameter int OUT_W = 16
) (
    input  logic signed [ACC_W-1:0] acc,
    input  logic [1:0]              mode,
    output logic [OUT_W-1:0]        res,
    output logic                    clamp
);
    localparam int DROP = 2 * OP_W - OUT_W;
    localparam int KW   = ACC_W - DROP;
    localparam int RW   = KW + 1;
    localparam logic signed [RW-1:0] OUT_MAX_X = {{(RW-OUT_W+1){1'b0}}, {(OUT_W-1){1'b1}}};
    localparam logic signed [RW-1:0] OUT_MIN_X = {{(RW-OUT_W+1){1'b1}}, {(OUT_W-1){1'b0}}};
    localparam logic [DROP-1:0]      TIE       = {1'b1, {(DROP-1){1'b0}}};

    logic signed [KW-1:0]   kept;
    logic [DROP-1:0]        frac;
    logic                   half;
    logic                   rest;
    logic                   inc;
    logic signed [RW-1:0]   kept_x;
    logic signed [RW-1:0]   rounded;
    logic                   hi;
    logic                   lo;

    assign kept = acc[ACC_W-1:DROP];
    assign frac = acc[DROP-1:0];
    assign half = frac[DROP-1];

    generate
        if (DROP > 1) begin : g_rest
            assign rest = |frac[DROP-2:0];
        end else begin : g_norest
            assign rest = 1'b0;
        end
    endgenerate

    always_comb begin
        case (rnd_mode_e'(mode))
            RND_HALFUP: inc = half;
            RND_EVEN:   inc = half & (rest | kept[0]);
            default:    inc = 1'b0;
        endcase
        kept_x  = {kept[KW-1], kept};
        rounded = kept_x + {{(RW-1){1'b0}}, inc};
        hi      = rounded > OUT_MAX_X;
        lo      = rounded < OUT_MIN_X;
        clamp   = hi | lo;
        if (hi)      res = OUT_MAX_X[OUT_W-1:0];
        else if (lo) res = OUT_MIN_X[OUT_W-1:0];
        else         res = rounded[OUT_W-1:0];
    end

    logic signed [RW-1:0] res_x;
    logic signed [RW-1:0] step;
    assign res_x = {{(RW-OUT_W){res[OUT_W-1]}}, res};
    assign step  = res_x - kept_x;

    // R7: an unclamped output never moves more than one LSB above the kept part
    always_comb begin
        if (!clamp) begin
            p_within_step_r7: assert (step == '0 || step == {{(RW-1){1'b0}}, 1'b1});
        end
    end

    // R8: an exact tie under half-to-even leaves an even output
    always_comb begin
        if (!clamp && rnd_mode_e'(mode) == RND_EVEN && frac == TIE) begin
            p_even_tie_r8: assert (res[0] == 1'b0);
        end
    end
endmodule

// File: rtl/fmac_core.sv
`timescale 1ns/1ps
module fmac_core
    import fmac_pkg::*;
#(
    parameter int OP_W  = 16,
    parameter int GUARD = 8,
    parameter int OUT_W = OP_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [1:0]       op,
    input  logic [OP_W-1:0]  opnd_a,
    input  logic [OP_W-1:0]  opnd_b,
    input  logic [1:0]       rnd_mode,
    input  logic             rd_en,
    output logic [OUT_W-1:0] result,
    output logic             sat_flag
);
    localparam int PW    = 2 * OP_W;
    localparam int ACC_W = PW + GUARD;

    typedef struct packed {
        logic signed [ACC_W-1:0] acc;
        logic [OUT_W-1:0]        res;
        logic                    flag;
    } state_t;

    state_t s_d, s_q;

    logic signed [PW-1:0]    prod;
    logic signed [ACC_W-1:0] prod_x;
    logic [OUT_W-1:0]        rs_res;
    logic                    rs_clamp;

    fmac_mult #(.OP_W(OP_W)) u_mult (
        .a    ($signed(opnd_a)),
        .b    ($signed(opnd_b)),
        .prod (prod)
    );

    assign prod_x = {{GUARD{prod[PW-1]}}, prod};

    fmac_rndsat #(.OP_W(OP_W), .ACC_W(ACC_W), .OUT_W(OUT_W)) u_rndsat (
        .acc   (s_q.acc),
        .mode  (rnd_mode),
        .res   (rs_res),
        .clamp (rs_clamp)
    );

    always_comb begin
        s_d = s_q;
        if (clr) begin
            s_d.acc = '0;
        end else begin
            case (mac_op_e'(op))
                OP_ADD:  s_d.acc = s_q.acc + prod_x;
                OP_SUB:  s_d.acc = s_q.acc - prod_x;
                OP_LOAD: s_d.acc = prod_x;
                default: s_d.acc = s_q.acc;
            endcase
        end
        if (rd_en) s_d.res = rs_res;
        s_d.flag = clr ? 1'b0 : (s_q.flag | (rd_en & rs_clamp));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign result   = s_q.res;
    assign sat_flag = s_q.flag;

    p_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && mac_op_e'(op) == OP_KEEP) |=> $stable(s_q.acc));

    p_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && mac_op_e'(op) == OP_LOAD) |=> (s_q.acc == $past(prod_x)));

    p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (s_q.acc == '0 && !sat_flag));

    p_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (sat_flag && !clr) |=> sat_flag);

    p_flag_src_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sat_flag) |-> $past(rd_en));

    p_result_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(result));
endmodule

// File: tb/sim_fmac_core.sv
`timescale 1ns/1ps
module sim_fmac_core;
    localparam int OP_W  = 16;
    localparam int GUARD = 8;
    localparam int ACC_W = 2 * OP_W + GUARD;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clr = 1'b0;
    logic [1:0]  op = 2'd0;
    logic [15:0] opnd_a = '0;
    logic [15:0] opnd_b = '0;
    logic [1:0]  rnd_mode = 2'd0;
    logic        rd_en = 1'b0;
    logic [15:0] result;
    logic        sat_flag;

    int total = 0;
    int bad = 0;

    longint m_acc = 0;
    longint m_res = 0;
    bit     m_flag = 1'b0;

    always #5 clk = ~clk;

    fmac_core #(.OP_W(OP_W), .GUARD(GUARD), .OUT_W(OP_W)) u0 (
        .clk(clk), .rst_n(rst_n), .clr(clr), .op(op),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .rnd_mode(rnd_mode),
        .rd_en(rd_en), .result(result), .sat_flag(sat_flag)
    );

    function automatic longint fprod(longint a, longint b);
        if (a == -32768 && b == -32768) return (longint'(1) <<< 31) - 1;
        return a * b * 2;
    endfunction

    function automatic longint wrap(longint v);
        longint m;
        m = v & ((longint'(1) <<< ACC_W) - 1);
        if (m[ACC_W-1]) m = m - (longint'(1) <<< ACC_W);
        return m;
    endfunction

    function automatic void rnd(input longint acc, input int mode,
                                output longint r, output bit c);
        longint kept, frac, v;
        bit inc;
        kept = acc >>> 16;
        frac = acc & 64'hFFFF;
        case (mode)
            1: inc = (frac >= 32768);
            2: inc = (frac > 32768) || (frac == 32768 && kept[0]);
            default: inc = 1'b0;
        endcase
        v = kept + longint'(inc);
        c = 1'b0;
        if (v > 32767)       begin r = 32767;  c = 1'b1; end
        else if (v < -32768) begin r = -32768; c = 1'b1; end
        else r = v;
    endfunction

    task automatic chk(input string req, input longint act, input longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One operation: drive at the falling edge, model the rising edge, sample at the next falling edge
    task automatic step(input bit c, input int o, input longint a, input longint b,
                        input bit rd, input int mode, input string req);
        longint r;
        bit     cl;
        longint p;
        clr = c; op = 2'(o); opnd_a = 16'(a); opnd_b = 16'(b);
        rd_en = rd; rnd_mode = 2'(mode);
        p = fprod(a, b);
        cl = 1'b0;
        if (rd) begin
            rnd(m_acc, mode, r, cl);
            m_res = r;
        end
        m_flag = c ? 1'b0 : (m_flag | (rd && cl));
        if (c) m_acc = 0;
        else case (o)
            1: m_acc = wrap(m_acc + p);
            2: m_acc = wrap(m_acc - p);
            3: m_acc = p;
            default: ;
        endcase
        @(posedge clk);
        @(negedge clk);
        chk(req, longint'($signed(result)), m_res);
        chk(req, longint'(sat_flag), longint'(m_flag));
    endtask

    task automatic rd_only(input int mode, input string req);
        step(1'b0, 0, 0, 0, 1'b1, mode, req);
    endtask

    initial begin
        #1_000_000;
        total++;
        bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20517));
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 result", longint'($signed(result)), 0);
        chk("R1 flag", longint'(sat_flag), 0);
        rst_n = 1'b1;
        @(negedge clk);
        rd_only(0, "R1 acc zero");

        // R2: fractional product, half times half and -1 times -1
        step(1'b0, 3, 16384, 16384, 1'b0, 0, "R2 load");
        rd_only(0, "R2 half*half");
        step(1'b0, 3, -32768, -32768, 1'b0, 0, "R2 load min");
        rd_only(0, "R2 min*min");
        step(1'b0, 3, -32768, 32767, 1'b0, 0, "R2 load mixed");
        rd_only(0, "R2 min*max");

        // R3 / R5: add, subtract, keep back to back
        step(1'b0, 3, 16384, 16384, 1'b0, 0, "R3 load");
        step(1'b0, 1, 16384, 16384, 1'b0, 0, "R5 add");
        step(1'b0, 1, 8192, 16384, 1'b1, 0, "R5 add with read");
        step(1'b0, 2, 16384, 16384, 1'b1, 0, "R3 sub");
        step(1'b0, 0, 12345, -2222, 1'b1, 0, "R3 keep");
        rd_only(0, "R3 keep ignored operands");

        // R4: clear has priority over op
        step(1'b1, 1, 32767, 32767, 1'b0, 0, "R4 clear");
        rd_only(0, "R4 acc zero");

        // R6 R7 R8 R12: ties and near-ties, both signs
        for (int k = 0; k < 6; k++) begin
            longint bb;
            bb = (k == 0) ? 5 : (k == 1) ? 7 : (k == 2) ? -5 : (k == 3) ? -7 : (k == 4) ? 9 : -9;
            step(1'b0, 3, 16384, bb, 1'b0, 0, "R8 tie load");
            rd_only(0, "R6 tie trunc");
            rd_only(1, "R7 tie half up");
            rd_only(2, "R8 tie even");
            rd_only(3, "R12 mode3 trunc");
            step(1'b0, 1, 1, 1, 1'b0, 0, "R8 above load");
            rd_only(2, "R8 above tie even");
            step(1'b0, 2, 1, 2, 1'b0, 0, "R8 below load");
            rd_only(1, "R7 below half up");
            rd_only(2, "R8 below even");
        end

        // R9: rounding before saturation
        step(1'b1, 0, 0, 0, 1'b0, 0, "R9 clear");
        step(1'b0, 3, -32768, -32768, 1'b0, 0, "R9 load max");
        rd_only(0, "R9 trunc no clamp");
        rd_only(1, "R9 round into clamp");
        rd_only(0, "R10 sticky after clean read");

        // R9 / R10: accumulate past range, both directions
        step(1'b1, 0, 0, 0, 1'b0, 0, "R10 clear");
        for (int i = 0; i < 3; i++) step(1'b0, 1, 32767, 32767, 1'b0, 0, "R9 pos run");
        rd_only(2, "R9 pos clamp");
        step(1'b1, 0, 0, 0, 1'b1, 0, "R10 clear wins");
        for (int i = 0; i < 3; i++) step(1'b0, 2, 32767, 32767, 1'b0, 0, "R9 neg run");
        rd_only(1, "R9 neg clamp");
        step(1'b0, 3, 100, 100, 1'b0, 0, "R10 small");
        rd_only(0, "R10 sticky");
        step(1'b1, 0, 0, 0, 1'b0, 0, "R10 clear flag");

        // R5 / R11: random traffic, one op per cycle
        for (int i = 0; i < 600; i++) begin
            bit     c;
            int     o;
            longint a, b;
            c = ($urandom % 24) == 0;
            o = int'($urandom % 4);
            a = longint'($signed(16'($urandom)));
            b = longint'($signed(16'($urandom)));
            if (($urandom % 8) == 0) a = -32768;
            if (($urandom % 8) == 0) b = (($urandom % 2) == 0) ? -32768 : 32767;
            step(c, o, a, b, ($urandom % 3) == 0, int'($urandom % 4), "R11 R5 random");
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule